// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block carries out, in hardware, the safe sequence for loading new multiplier, pre-divider and post-divider settings into a PLL. A start pulse in idle captures the new target values and a timeout limit. The block then commands the PLL into bypass and waits until the bypass flag is up and the locked flag is down. After that it pulses a write strobe for the multiplier and pre-divider, then a second strobe for the post-divider. Finally it commands lock and waits until the locked flag is up and the bypass flag is down. It then pulses done.

Each of the two waits is bounded by the captured timeout limit. If a wait runs out, the block sets a sticky error flag, leaves the PLL in bypass and goes back to idle. The error flag clears on the next accepted start. Start pulses that arrive while a sequence is running have no effect.

Top module: `pll_reprog_seq`

## Requirements
- R1: Out of reset, mode_o is 3'h7 (lock code). Both strobes, busy_o, done_o and err_o are 0.
- R2: A start_i sampled high while busy_o is 0 is accepted. From the next cycle, mode_o is 3'h4 (bypass code), busy_o is 1, err_o is 0, and the value outputs show the captured targets.
- R3: In the bypass wait, md_wr_o rises for exactly one cycle. This happens in the cycle after bypass_st_i=1 and locked_st_i=0 are first sampled together. While either flag differs, no write takes place.
- R4: post_wr_o is high for exactly the one cycle that follows the md_wr_o cycle.
- R5: mode_o becomes 3'h7 in the cycle after the post_wr_o cycle. The block then waits for locked_st_i=1 with bypass_st_i=0.
- R6: done_o is a one-cycle pulse in the cycle after the lock condition is sampled. busy_o drops in that same cycle.
- R7: Let L be the timeout limit captured at start. If a wait sees its condition false on L+1 consecutive cycles, then in the next cycle err_o is set, busy_o drops and mode_o is 3'h4. This applies to both waits. err_o then holds until the next accepted start.
- R8: A start_i that arrives while busy_o is 1 has no effect on any output or on the captured values.
- R9: mult_o, div_o and post_o change only when a start is accepted.
- R10: With a limit of 0, a wait whose condition is false on its first cycle ends in error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request |
| mult_i | input | 11 | Target multiplier |
| div_i | input | 7 | Target pre-divider |
| post_i | input | 5 | Target post-divider |
| timeout_i | input | 16 | Wait limit in cycles, minus one |
| bypass_st_i | input | 1 | PLL bypass status flag |
| locked_st_i | input | 1 | PLL locked status flag |
| mode_o | output | 3 | Mode command: 3'h4 bypass, 3'h7 lock |
| mult_o | output | 11 | Captured multiplier |
| div_o | output | 7 | Captured pre-divider |
| md_wr_o | output | 1 | Multiplier and pre-divider write strobe |
| post_o | output | 5 | Captured post-divider |
| post_wr_o | output | 1 | Post-divider write strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky timeout error |

## Verification
The assertions assume that the status flags are synchronous to clk and are sampled only at clock edges. They also assume that start_i, the targets and the timeout limit are stable while they are sampled. The bench PLL model meets these assumptions by updating both flags on the falling edge, with a programmable delay after each mode change. It can also hold the locked flag high after bypass is reached, and it can refuse to ever answer, so that the timeout paths are driven. All stimulus inputs change only on the falling edge.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;
    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_BYPASS = 3'h4;
    localparam logic [MODE_W-1:0] MODE_LOCK   = 3'h7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_BYP,
        ST_WR_MD,
        ST_WR_POST,
        ST_WAIT_LOCK
    } seq_state_e;
endpackage

// File: rtl/pllseq_wait_timer.sv
module pllseq_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == limit_i);
endmodule

// File: rtl/pllseq_value_regs.sv
module pllseq_value_regs #(
    parameter int MULT_W = 11,
    parameter int DIV_W  = 7,
    parameter int POST_W = 5,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [POST_W-1:0] post_i,
    input  logic [TMO_W-1:0]  tmo_i,
    output logic [MULT_W-1:0] mult_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [POST_W-1:0] post_o,
    output logic [TMO_W-1:0]  tmo_o
);
    localparam int TOT_W = MULT_W + DIV_W + POST_W + TMO_W;

    logic [TOT_W-1:0] vals_d, vals_q;

    always_comb begin
        vals_d = vals_q;
        if (load_i) vals_d = {mult_i, div_i, post_i, tmo_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vals_q <= '0;
        else        vals_q <= vals_d;
    end

    assign {mult_o, div_o, post_o, tmo_o} = vals_q;
endmodule

// File: rtl/pllseq_core.sv
module pllseq_core
    import pllseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              bypass_st_i,
    input  logic              locked_st_i,
    input  logic              expired_i,
    output logic              tmr_clr_o,
    output logic              load_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              md_wr_o,
    output logic              post_wr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    typedef struct packed {
        seq_state_e        st;
        logic [MODE_W-1:0] mode;
        logic              md_wr;
        logic              post_wr;
        logic              busy;
        logic              done;
        logic              err;
    } core_regs_t;

    localparam core_regs_t RESET_VAL = '{
        st: ST_IDLE, mode: MODE_LOCK, md_wr: 1'b0, post_wr: 1'b0,
        busy: 1'b0, done: 1'b0, err: 1'b0
    };

    core_regs_t r_d, r_q;
    logic       byp_ok, lock_ok;

    assign byp_ok  = bypass_st_i && !locked_st_i;
    assign lock_ok = locked_st_i && !bypass_st_i;

    always_comb begin
        r_d         = r_q;
        r_d.md_wr   = 1'b0;
        r_d.post_wr = 1'b0;
        r_d.done    = 1'b0;
        tmr_clr_o   = 1'b0;
        load_o      = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                tmr_clr_o = 1'b1;
                if (start_i) begin
                    load_o   = 1'b1;
                    r_d.st   = ST_WAIT_BYP;
                    r_d.mode = MODE_BYPASS;
                    r_d.busy = 1'b1;
                    r_d.err  = 1'b0;
                end
            end
            ST_WAIT_BYP: begin
                if (byp_ok) begin
                    r_d.st    = ST_WR_MD;
                    r_d.md_wr = 1'b1;
                end else if (expired_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.err  = 1'b1;
                end
            end
            ST_WR_MD: begin
                r_d.st      = ST_WR_POST;
                r_d.post_wr = 1'b1;
            end
            ST_WR_POST: begin
                tmr_clr_o = 1'b1;
                r_d.st    = ST_WAIT_LOCK;
                r_d.mode  = MODE_LOCK;
            end
            ST_WAIT_LOCK: begin
                if (lock_ok) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                end else if (expired_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.err  = 1'b1;
                    r_d.mode = MODE_BYPASS;
                end
            end
            default: r_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign mode_o    = r_q.mode;
    assign md_wr_o   = r_q.md_wr;
    assign post_wr_o = r_q.post_wr;
    assign busy_o    = r_q.busy;
    assign done_o    = r_q.done;
    assign err_o     = r_q.err;
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pllseq_pkg::*;
#(
    parameter int MULT_W = 11,
    parameter int DIV_W  = 7,
    parameter int POST_W = 5,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [POST_W-1:0] post_i,
    input  logic [TMO_W-1:0]  timeout_i,
    input  logic              bypass_st_i,
    input  logic              locked_st_i,
    output logic [2:0]        mode_o,
    output logic [MULT_W-1:0] mult_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              md_wr_o,
    output logic [POST_W-1:0] post_o,
    output logic              post_wr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    logic             tmr_clr, expired, load;
    logic [TMO_W-1:0] limit;

    pllseq_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .bypass_st_i(bypass_st_i),
        .locked_st_i(locked_st_i),
        .expired_i  (expired),
        .tmr_clr_o  (tmr_clr),
        .load_o     (load),
        .mode_o     (mode_o),
        .md_wr_o    (md_wr_o),
        .post_wr_o  (post_wr_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    pllseq_value_regs #(
        .MULT_W(MULT_W), .DIV_W(DIV_W), .POST_W(POST_W), .TMO_W(TMO_W)
    ) u_vals (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load),
        .mult_i(mult_i),
        .div_i (div_i),
        .post_i(post_i),
        .tmo_i (timeout_i),
        .mult_o(mult_o),
        .div_o (div_o),
        .post_o(post_o),
        .tmo_o (limit)
    );

    pllseq_wait_timer #(.CNT_W(TMO_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (tmr_clr),
        .limit_i  (limit),
        .expired_o(expired)
    );
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
    parameter int MULT_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              bypass_st_i,
    input logic              locked_st_i,
    input logic [2:0]        mode_o,
    input logic [MULT_W-1:0] mult_o,
    input logic              md_wr_o,
    input logic              post_wr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o
);
    p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'h4) || (mode_o == 3'h7));

    p_md_after_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        md_wr_o |-> $past(bypass_st_i && !locked_st_i));

    p_post_after_md_r4: assert property (@(posedge clk) disable iff (!rst_n)
        post_wr_o |-> $past(md_wr_o));

    p_lock_after_post_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'h7 && $past(mode_o) != 3'h7) |-> $past(post_wr_o));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_needs_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(locked_st_i && !bypass_st_i) && !busy_o));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_o) && !err_o) |-> $past(start_i && !busy_o));

    p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> $stable(mult_o));
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(.MULT_W(MULT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .bypass_st_i(bypass_st_i),
    .locked_st_i(locked_st_i),
    .mode_o     (mode_o),
    .mult_o     (mult_o),
    .md_wr_o    (md_wr_o),
    .post_wr_o  (post_wr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/pll_reprog_seq_tb.sv
module pll_reprog_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [10:0] mult_i = '0;
    logic [6:0]  div_i = '0;
    logic [4:0]  post_i = '0;
    logic [15:0] timeout_i = '0;
    logic        bypass_st_i = 1'b0;
    logic        locked_st_i = 1'b1;
    logic [2:0]  mode_o;
    logic [10:0] mult_o;
    logic [6:0]  div_o;
    logic        md_wr_o;
    logic [4:0]  post_o;
    logic        post_wr_o;
    logic        busy_o, done_o, err_o;

    always #4 clk = ~clk;

    pll_reprog_seq dut_i (.*);

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    // PLL model knobs
    int lat_b = 3, lat_l = 5, lag = 0;
    bit stuck_b = 0, stuck_l = 0;
    int age = 1000;
    logic [2:0] last_mode = 3'h7;

    // Reference model
    int m_st = 0, m_cnt = 0, m_lim = 0;
    int m_mode = 7, m_mult = 0, m_div = 0, m_post = 0;
    bit m_md = 0, m_pw = 0, m_done = 0, m_busy = 0, m_err = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_mode = 7; m_mult = 0; m_div = 0; m_post = 0;
            m_md = 0; m_pw = 0; m_done = 0; m_busy = 0; m_err = 0; m_cnt = 0;
        end else begin
            m_md = 0; m_pw = 0; m_done = 0;
            case (m_st)
                0: if (start_i) begin
                    m_st = 1; m_mode = 4; m_busy = 1; m_err = 0; m_cnt = 0;
                    m_mult = mult_i; m_div = div_i; m_post = post_i; m_lim = timeout_i;
                end
                1: if (bypass_st_i && !locked_st_i) begin m_st = 2; m_md = 1; end
                   else if (m_cnt == m_lim) begin m_st = 0; m_busy = 0; m_err = 1; end
                   else m_cnt++;
                2: begin m_st = 3; m_pw = 1; end
                3: begin m_st = 4; m_mode = 7; m_cnt = 0; end
                default: if (locked_st_i && !bypass_st_i) begin m_st = 0; m_done = 1; m_busy = 0; end
                   else if (m_cnt == m_lim) begin m_st = 0; m_busy = 0; m_err = 1; m_mode = 4; end
                   else m_cnt++;
            endcase
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // compare every clock, then update PLL status
    always @(negedge clk) begin
        cyc++;
        if (!finished) begin
            chk(rst_n ? "R2/R5/R7" : "R1", "mode_o", int'(mode_o), m_mode);
            chk(rst_n ? "R3" : "R1", "md_wr_o", int'(md_wr_o), int'(m_md));
            chk(rst_n ? "R4" : "R1", "post_wr_o", int'(post_wr_o), int'(m_pw));
            chk(rst_n ? "R6" : "R1", "done_o", int'(done_o), int'(m_done));
            chk(rst_n ? "R8" : "R1", "busy_o", int'(busy_o), int'(m_busy));
            chk(rst_n ? "R7" : "R1", "err_o", int'(err_o), int'(m_err));
            chk("R9", "mult_o", int'(mult_o), m_mult);
            chk("R9", "div_o", int'(div_o), m_div);
            chk("R9", "post_o", int'(post_o), m_post);
        end
        if (mode_o != last_mode) age = 0; else if (age < 1000) age++;
        last_mode = mode_o;
        if (mode_o == 3'h4) begin
            bypass_st_i = !stuck_b && age >= lat_b;
            locked_st_i = !(age >= lat_b + lag);
        end else begin
            locked_st_i = !stuck_l && age >= lat_l;
            bypass_st_i = !(age >= lat_l);
        end
        if (cyc > 20000 && !finished) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic go(int m, int d, int p, int lim);
        @(negedge clk);
        start_i = 1; mult_i = m[10:0]; div_i = d[6:0]; post_i = p[4:0]; timeout_i = lim[15:0];
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!busy_o) break;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset mode", int'(mode_o), 7);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // normal run
        lat_b = 3; lat_l = 5;
        go(11'h5A3, 7'h17, 5'h01, 50);
        wait_idle();
        chk("R6", "ends locked", int'(mode_o), 7);
        // fast PLL
        lat_b = 1; lat_l = 1;
        go(11'h7FF, 7'h7F, 5'h1F, 10);
        wait_idle();
        // bypass reached while lock flag lingers (two-flag check)
        lat_b = 2; lag = 6; lat_l = 4;
        go(11'h012, 7'h03, 5'h09, 40);
        wait_idle();
        lag = 0;
        // bypass never confirmed: timeout
        stuck_b = 1;
        go(11'h100, 7'h10, 5'h02, 4);
        wait_idle();
        chk("R7", "err after bypass timeout", int'(err_o), 1);
        chk("R7", "mode left bypass", int'(mode_o), 4);
        stuck_b = 0;
        // lock never reached, limit 0
        stuck_l = 1;
        go(11'h200, 7'h20, 5'h04, 0);
        wait_idle();
        chk("R10", "err with zero limit", int'(err_o), 1);
        chk("R7", "mode back to bypass", int'(mode_o), 4);
        stuck_l = 0;
        // start while busy
        lat_b = 6; lat_l = 6;
        go(11'h333, 7'h33, 5'h13, 60);
        go(11'h444, 7'h44, 5'h14, 2);
        chk("R8", "mult kept", int'(mult_o), 11'h333);
        wait_idle();
        chk("R8", "post kept", int'(post_o), 5'h13);
        chk("R7", "err cleared by new start", int'(err_o), 0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule